// File: doc/BRIEF.md
# Two-Sector Cache Victim Selector

This block handles replacement for a 12-way set-associative cache with 128-byte lines. Software can split the ways of the cache between two sectors. For every way of every set it holds a valid bit, an owning-sector bit, an MRU bit and the line tag. Each lookup is decided in the cycle it is presented: it reports hit or miss and the hit way. On a miss it also reports the way to fill and, when that way holds a line, the tag being evicted. The state update happens on the next clock edge.

The sector of a request comes from a single bit. Plain accesses drive 0 (sector 0), and only explicitly marked accesses drive 1 (sector 1). Software gives each sector a way quota through two 4-bit size inputs, plus an enable. The intended pairs are (s, 12-s) for s from 1 to 11, and sums below 12 are also accepted. When partitioning is on, each sector keeps its own pseudo-LRU order. A sector can grow into free ways beyond its quota, but never into the part that the other sector has reserved and not yet used. When partitioning is off, the whole set shares one pseudo-LRU order.

Top module: `sector_victim_sel`

## Requirements
- R1: After reset every line is invalid, so the first miss to any set picks way 0 with evict_valid_o low.
- R2: A request hits when a valid way of the addressed set holds the request tag, whatever its sector. hit_o is then high, way_o is that way and evict_valid_o is low, and the next identical request also hits.
- R3: With partitioning on, a miss in a full set never evicts a line of the other sector while the requester owns at least one line of the set.
- R4: With partitioning on, a miss from a sector below its quota fills the lowest-numbered invalid way, if one exists, without eviction.
- R5: With partitioning on, a sector at or above its quota may still fill an invalid way when the invalid ways outnumber the other sector's unused reservation (its quota minus its lines, floored at 0). Otherwise it evicts its own pseudo-LRU line.
- R6: Each hit or fill sets the way's MRU bit. When all ways of that group in the set are then set, the other bits of the group are cleared. The group is the ways of the line's sector, or all 12 ways when partitioning is off. The pseudo-LRU victim is the lowest-numbered eligible way whose MRU bit is clear.
- R7: A fill records the request sector (0 = plain access, 1 = marked access) as the line owner. A hit from the other sector does not change the owner.
- R8: An invalidate clears the valid bit and the MRU bit of the named set and way. This lowers that sector's line count, and the freed way is reused by a later miss.
- R9: With partitioning off, a miss fills the lowest invalid way. In a full set it evicts the lowest way whose MRU bit is clear, taken over all 12 ways.
- R10: evict_valid_o is high only on a miss whose chosen way holds a valid line, and evict_tag_o then gives that line's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| part_en_i | input | 1 | Partitioning enable |
| size0_i | input | 4 | Way quota of sector 0 |
| size1_i | input | 4 | Way quota of sector 1 |
| req_valid_i | input | 1 | Lookup request present |
| req_set_i | input | 4 | Set index of the lookup |
| req_tag_i | input | 10 | Tag of the lookup |
| req_sector_i | input | 1 | Requesting sector (0 plain, 1 marked) |
| inv_valid_i | input | 1 | Invalidate request |
| inv_set_i | input | 4 | Set to invalidate |
| inv_way_i | input | 4 | Way to invalidate |
| hit_o | output | 1 | Lookup hit |
| way_o | output | 4 | Hit way or fill way |
| evict_valid_o | output | 1 | Fill displaces a valid line |
| evict_tag_o | output | 10 | Tag of the displaced line |

## Verification
Corrupted owner, valid or MRU bits do not show up at once. They show up at the ports on the next miss to the affected set: the fill way is wrong, or an eviction appears where a free way should have been taken. A stale tag shows up as a false hit, or as a wrong evict_tag_o the next time that way is chosen. The scoreboard compares every lookup against a model of the set state. As a result, a state error is reported on the first request to the set that it changes, usually within a few cycles of the bad update.

// File: rtl/svs_pkg.sv
package svs_pkg;
  localparam logic SEC_PLAIN  = 1'b0;
  localparam logic SEC_MARKED = 1'b1;

  // quota the other sector has not filled yet, floored at zero
  function automatic logic [3:0] unused_share(input logic [3:0] quota, input logic [3:0] held);
    return (quota > held) ? quota - held : 4'd0;
  endfunction
endpackage

// File: rtl/svs_lowest_pick.sv
module svs_lowest_pick #(
  parameter int N     = 12,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = |req_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/svs_popcount.sv
module svs_popcount #(
  parameter int N  = 12,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/svs_mru_next.sv
module svs_mru_next #(
  parameter int N = 12
) (
  input  logic [N-1:0] mru_i,
  input  logic [N-1:0] group_i,
  input  logic [N-1:0] way_oh_i,
  output logic [N-1:0] mru_o
);
  logic [N-1:0] set_v;
  always_comb begin
    set_v = mru_i | way_oh_i;
    if ((set_v & group_i) == group_i) mru_o = (set_v & ~group_i) | way_oh_i;
    else                              mru_o = set_v;
  end
endmodule

// File: rtl/sector_victim_sel.sv
module sector_victim_sel #(
  parameter int NUM_WAYS = 12,
  parameter int NUM_SETS = 16,
  parameter int TAG_W    = 10,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int CNT_W   = $clog2(NUM_WAYS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             part_en_i,
  input  logic [CNT_W-1:0] size0_i,
  input  logic [CNT_W-1:0] size1_i,
  input  logic             req_valid_i,
  input  logic [SET_W-1:0] req_set_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic             req_sector_i,
  input  logic             inv_valid_i,
  input  logic [SET_W-1:0] inv_set_i,
  input  logic [WAY_W-1:0] inv_way_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] way_o,
  output logic             evict_valid_o,
  output logic [TAG_W-1:0] evict_tag_o
);
  import svs_pkg::*;

  localparam logic [NUM_WAYS-1:0] ONE_W = {{(NUM_WAYS-1){1'b0}}, 1'b1};

  logic [NUM_WAYS-1:0] valid_q [NUM_SETS];
  logic [NUM_WAYS-1:0] sec_q   [NUM_SETS];
  logic [NUM_WAYS-1:0] mru_q   [NUM_SETS];
  logic [TAG_W-1:0]    tag_q   [NUM_SETS][NUM_WAYS];

  logic [NUM_WAYS-1:0] rd_valid, rd_sec, rd_mru;
  logic [NUM_WAYS-1:0] match_vec, own_mask, oth_mask, inv_mask;
  logic [NUM_WAYS-1:0] lru_pool, lru_clear;
  logic [CNT_W-1:0]    own_cnt, oth_cnt, inv_cnt, quota, oth_quota, unmet;
  logic                hit_found, inv_found, clr_found, pool_found;
  logic [WAY_W-1:0]    hit_idx, inv_idx, clr_idx, pool_idx, victim;
  logic                take_invalid, owner, vic_sec;
  logic [NUM_WAYS-1:0] acc_oh, new_valid, new_sec, new_mru, grp, inv_same;

  assign rd_valid = valid_q[req_set_i];
  assign rd_sec   = sec_q[req_set_i];
  assign rd_mru   = mru_q[req_set_i];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign match_vec[w] = rd_valid[w] && (tag_q[req_set_i][w] == req_tag_i);
    assign own_mask[w]  = rd_valid[w] && (rd_sec[w] == req_sector_i);
    assign grp[w]       = !part_en_i || (new_valid[w] && (new_sec[w] == owner));
  end

  assign oth_mask = rd_valid & ~own_mask;
  assign inv_mask = ~rd_valid;

  svs_popcount #(.N(NUM_WAYS), .CW(CNT_W)) u_cnt_own (.vec_i(own_mask), .cnt_o(own_cnt));
  svs_popcount #(.N(NUM_WAYS), .CW(CNT_W)) u_cnt_oth (.vec_i(oth_mask), .cnt_o(oth_cnt));
  svs_popcount #(.N(NUM_WAYS), .CW(CNT_W)) u_cnt_inv (.vec_i(inv_mask), .cnt_o(inv_cnt));

  assign quota     = (req_sector_i == SEC_MARKED) ? size1_i : size0_i;
  assign oth_quota = (req_sector_i == SEC_MARKED) ? size0_i : size1_i;
  assign unmet     = CNT_W'(unused_share(4'(oth_quota), 4'(oth_cnt)));

  // grow into a free way unless it would eat the other sector's reservation
  assign take_invalid = inv_found &&
                        (!part_en_i || (own_cnt < quota) || (inv_cnt > unmet) || (own_cnt == '0));

  assign lru_pool  = (part_en_i && own_cnt != '0) ? own_mask : rd_valid;
  assign lru_clear = lru_pool & ~rd_mru;

  svs_lowest_pick #(.N(NUM_WAYS), .IDX_W(WAY_W)) u_pick_hit  (.req_i(match_vec), .found_o(hit_found),  .idx_o(hit_idx));
  svs_lowest_pick #(.N(NUM_WAYS), .IDX_W(WAY_W)) u_pick_inv  (.req_i(inv_mask),  .found_o(inv_found),  .idx_o(inv_idx));
  svs_lowest_pick #(.N(NUM_WAYS), .IDX_W(WAY_W)) u_pick_clr  (.req_i(lru_clear), .found_o(clr_found),  .idx_o(clr_idx));
  svs_lowest_pick #(.N(NUM_WAYS), .IDX_W(WAY_W)) u_pick_pool (.req_i(lru_pool),  .found_o(pool_found), .idx_o(pool_idx));

  always_comb begin
    if (take_invalid)    victim = inv_idx;
    else if (clr_found)  victim = clr_idx;
    else                 victim = pool_idx;
  end

  assign hit_o         = req_valid_i && hit_found;
  assign way_o         = hit_found ? hit_idx : victim;
  assign evict_valid_o = req_valid_i && !hit_found && rd_valid[victim];
  assign evict_tag_o   = tag_q[req_set_i][victim];
  assign vic_sec       = rd_sec[victim];

  assign acc_oh    = ONE_W << way_o;
  assign owner     = hit_found ? rd_sec[hit_idx] : req_sector_i;
  assign new_valid = rd_valid | acc_oh;
  assign new_sec   = hit_found ? rd_sec
                   : ((rd_sec & ~acc_oh) | (req_sector_i ? acc_oh : '0));

  svs_mru_next #(.N(NUM_WAYS)) u_mru (
    .mru_i   (rd_mru),
    .group_i (grp),
    .way_oh_i(acc_oh),
    .mru_o   (new_mru)
  );

  assign inv_same = (inv_valid_i && inv_set_i == req_set_i && 32'(inv_way_i) < NUM_WAYS)
                  ? ((ONE_W << inv_way_i) & ~acc_oh) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        valid_q[s] <= '0;
        sec_q[s]   <= '0;
        mru_q[s]   <= '0;
      end
    end else begin
      if (req_valid_i) begin
        valid_q[req_set_i] <= new_valid & ~inv_same;
        sec_q[req_set_i]   <= new_sec;
        mru_q[req_set_i]   <= new_mru & ~inv_same;
      end
      if (inv_valid_i && 32'(inv_way_i) < NUM_WAYS && !(req_valid_i && inv_set_i == req_set_i)) begin
        valid_q[inv_set_i][inv_way_i] <= 1'b0;
        mru_q[inv_set_i][inv_way_i]   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (req_valid_i && !hit_found) tag_q[req_set_i][victim] <= req_tag_i;
  end
endmodule

// File: rtl/svs_checker.sv
module svs_checker #(
  parameter int NUM_WAYS = 12,
  parameter int SET_W    = 4,
  parameter int TAG_W    = 10,
  parameter int WAY_W    = 4,
  parameter int CNT_W    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             part_en_i,
  input logic             req_valid_i,
  input logic [SET_W-1:0] req_set_i,
  input logic [TAG_W-1:0] req_tag_i,
  input logic             req_sector_i,
  input logic             inv_valid_i,
  input logic             hit_o,
  input logic [WAY_W-1:0] way_o,
  input logic             evict_valid_o,
  input logic [CNT_W-1:0] own_cnt,
  input logic [CNT_W-1:0] inv_cnt,
  input logic [CNT_W-1:0] quota,
  input logic             vic_sec
);
  p_hit_no_evict_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && hit_o) |-> !evict_valid_o);

  p_refill_hits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && $past(req_valid_i) && !$past(hit_o) && !$past(inv_valid_i)
     && req_set_i == $past(req_set_i) && req_tag_i == $past(req_tag_i))
    |-> (hit_o && way_o == $past(way_o)));

  p_isolation_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !hit_o && part_en_i && own_cnt != '0 && evict_valid_o)
    |-> (vic_sec == req_sector_i));

  p_below_quota_free_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !hit_o && part_en_i && own_cnt < quota && inv_cnt != '0)
    |-> !evict_valid_o);

  p_shared_free_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !hit_o && !part_en_i && inv_cnt != '0) |-> !evict_valid_o);
endmodule

bind sector_victim_sel svs_checker #(
  .NUM_WAYS(NUM_WAYS), .SET_W(SET_W), .TAG_W(TAG_W), .WAY_W(WAY_W), .CNT_W(CNT_W)
) u_svs_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .part_en_i    (part_en_i),
  .req_valid_i  (req_valid_i),
  .req_set_i    (req_set_i),
  .req_tag_i    (req_tag_i),
  .req_sector_i (req_sector_i),
  .inv_valid_i  (inv_valid_i),
  .hit_o        (hit_o),
  .way_o        (way_o),
  .evict_valid_o(evict_valid_o),
  .own_cnt      (own_cnt),
  .inv_cnt      (inv_cnt),
  .quota        (quota),
  .vic_sec      (vic_sec)
);

// File: tb/tb_sector_victim_sel.sv
module tb_sector_victim_sel;
  localparam int NW = 12;
  localparam int NS = 16;
  localparam int TW = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            part_en = 1'b0;
  logic [3:0]      size0 = 4'd0, size1 = 4'd0;
  logic            req_valid = 1'b0;
  logic [3:0]      req_set = '0;
  logic [TW-1:0]   req_tag = '0;
  logic            req_sector = 1'b0;
  logic            inv_valid = 1'b0;
  logic [3:0]      inv_set = '0, inv_way = '0;
  logic            hit;
  logic [3:0]      way;
  logic            ev;
  logic [TW-1:0]   ev_tag;

  always #10 clk = ~clk;

  sector_victim_sel dut (
    .clk_i(clk), .rst_ni(rst_n), .part_en_i(part_en), .size0_i(size0), .size1_i(size1),
    .req_valid_i(req_valid), .req_set_i(req_set), .req_tag_i(req_tag), .req_sector_i(req_sector),
    .inv_valid_i(inv_valid), .inv_set_i(inv_set), .inv_way_i(inv_way),
    .hit_o(hit), .way_o(way), .evict_valid_o(ev), .evict_tag_o(ev_tag)
  );

  typedef struct packed {
    logic          hit;
    logic [3:0]    way;
    logic          ev;
    logic [TW-1:0] tag;
  } exp_t;

  exp_t  exp_q[$];
  string rq_q[$];
  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 0;

  // reference set state
  bit          m_v [NS][NW];
  bit          m_s [NS][NW];
  bit          m_m [NS][NW];
  int          m_t [NS][NW];

  task automatic access(input int set, input int tag, input bit sec, input string rq);
    exp_t e;
    int hw = -1, vw = -1, own = 0, oth = 0, inv = 0, q, oq, unmet;
    bit take_inv, owner, all_set;
    @(negedge clk);
    req_valid = 1'b1; req_set = 4'(set); req_tag = TW'(tag); req_sector = sec;
    for (int w = 0; w < NW; w++)
      if (hw < 0 && m_v[set][w] && m_t[set][w] == tag) hw = w;
    e = '0;
    if (hw >= 0) begin
      e.hit = 1'b1; e.way = 4'(hw); owner = m_s[set][hw]; vw = hw;
    end else begin
      for (int w = 0; w < NW; w++) begin
        if (!m_v[set][w]) inv++;
        else if (m_s[set][w] == sec) own++;
        else oth++;
      end
      q = sec ? int'(size1) : int'(size0);
      oq = sec ? int'(size0) : int'(size1);
      unmet = (oq > oth) ? oq - oth : 0;
      take_inv = inv > 0 && (!part_en || own < q || inv > unmet || own == 0);
      if (take_inv) begin
        for (int w = NW - 1; w >= 0; w--) if (!m_v[set][w]) vw = w;
      end else begin
        for (int w = NW - 1; w >= 0; w--)
          if (m_v[set][w] && (!part_en || own == 0 || m_s[set][w] == sec) && !m_m[set][w]) vw = w;
        if (vw < 0)
          for (int w = NW - 1; w >= 0; w--)
            if (m_v[set][w] && (!part_en || own == 0 || m_s[set][w] == sec)) vw = w;
      end
      e.way = 4'(vw);
      e.ev  = m_v[set][vw];
      e.tag = TW'(m_t[set][vw]);
      m_v[set][vw] = 1'b1; m_t[set][vw] = tag; m_s[set][vw] = sec; owner = sec;
    end
    m_m[set][vw] = 1'b1;
    all_set = 1'b1;
    for (int w = 0; w < NW; w++)
      if ((!part_en || (m_v[set][w] && m_s[set][w] == owner)) && !m_m[set][w]) all_set = 1'b0;
    if (all_set)
      for (int w = 0; w < NW; w++)
        if ((!part_en || (m_v[set][w] && m_s[set][w] == owner)) && w != vw) m_m[set][w] = 1'b0;
    exp_q.push_back(e);
    rq_q.push_back(rq);
  endtask

  task automatic invalidate(input int set, input int w);
    @(negedge clk);
    req_valid = 1'b0; inv_valid = 1'b1; inv_set = 4'(set); inv_way = 4'(w);
    m_v[set][w] = 1'b0; m_m[set][w] = 1'b0;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: compare mid-cycle, before the next active edge
  initial begin
    forever begin
      @(negedge clk);
      #8;
      if (exp_q.size() > 0) begin
        exp_t e;
        string rq;
        e = exp_q.pop_front();
        rq = rq_q.pop_front();
        n_checks++;
        if (hit !== e.hit || way !== e.way || ev !== e.ev || (e.ev && ev_tag !== e.tag)) begin
          n_fail++;
          $display("FAIL %s: got hit=%0b way=%0d ev=%0b tag=%0h, expected hit=%0b way=%0d ev=%0b tag=%0h",
                   rq, hit, way, ev, ev_tag, e.hit, e.way, e.ev, e.tag);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, first miss lands in way 0
    part_en = 1'b1; size0 = 4'd4; size1 = 4'd8;
    access(0, 'h11, 0, "R1");
    access(0, 'h11, 0, "R2");
    // R4: quotas 4/8, fills go to lowest free way
    for (int i = 0; i < 4; i++) access(1, 'h20 + i, 0, "R4");
    for (int i = 0; i < 8; i++) access(1, 'h30 + i, 1, "R4");
    // R2/R7: marked access hits a plain line, owner kept
    access(1, 'h21, 1, "R7");
    // R6: per-sector pseudo-LRU order
    access(1, 'h24, 0, "R6");
    access(1, 'h25, 0, "R6");
    access(1, 'h26, 0, "R7");
    access(1, 'h27, 0, "R7");
    // R3: sector 1 misses stay inside ways 4..11
    for (int i = 0; i < 9; i++) access(1, 'h38 + i, 1, "R3");
    access(1, 'h27, 1, "R2");
    // R5: quotas 3/3, sector 0 grows past its quota, stops at the reservation
    size0 = 4'd3; size1 = 4'd3;
    for (int i = 0; i < 9; i++) access(2, 'h40 + i, 0, "R5");
    access(2, 'h49, 0, "R5");
    access(2, 'h4a, 0, "R10");
    for (int i = 0; i < 3; i++) access(2, 'h50 + i, 1, "R4");
    access(2, 'h53, 1, "R3");
    // R8: invalidate frees a way that is then reused
    idle();
    invalidate(2, 4);
    access(2, 'h54, 1, "R8");
    access(2, 'h44, 0, "R8");
    // R9: shared replacement
    idle();
    part_en = 1'b0;
    for (int i = 0; i < 12; i++) access(3, 'h60 + i, 1'(i), "R9");
    access(3, 'h70, 0, "R9");
    access(3, 'h71, 1, "R9");
    access(3, 'h63, 0, "R2");
    access(3, 'h72, 0, "R10");
    idle();
    invalidate(3, 7);
    access(3, 'h73, 1, "R8");
    idle();
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule